// File: doc/BRIEF.md
# Buffered Edge/Center-Aligned PWM Timer

This block is a 16-bit timer that drives one pulse-width-modulated output. It has two counting modes. In edge-aligned mode the counter climbs from zero to a modulo limit and then wraps. In center-aligned mode it climbs to the limit and then falls back to zero, so the pulse sits symmetrically around count zero. A one-cycle overflow pulse marks the end of each counting period.

Software programs the modulo limit and the duty threshold one byte at a time. Each 16-bit value goes through its own pair buffer. A byte pair is complete only once the high byte and then the low byte have been written. A completed pair reaches the active register only on the counting step from limit−1 to limit, which is the period boundary. This keeps every PWM period whole and free of glitches. While the counter clock is switched off, a completed pair loads at once.

The counter runs as a small state machine. `CT_IDLE` is the state after reset. `CT_UP` is the rising phase and `CT_DOWN` is the falling phase. On the first enabled tick the machine leaves `CT_IDLE` for `CT_UP` or wraps. In center mode it goes from `CT_UP` to `CT_DOWN` when the count reaches the limit, and from `CT_DOWN` to `CT_UP` at count zero. In edge mode it stays in `CT_UP` or returns there. Each pair buffer is a second state machine. `PB_EMPTY` moves to `PB_HALF` on a high-byte write. `PB_HALF` moves to `PB_FULL` on a low-byte write. Another high-byte write returns the buffer to `PB_HALF`. `PB_FULL` moves to `PB_EMPTY` when the value is loaded. The modulo buffer also moves to `PB_EMPTY` when the control register is written outside debug halt.

Top module: `pwm_buf_timer`

## Requirements
- R1: After reset the output `pwm_out` is 0 and `ovf_flag` is 0. The modulo and threshold registers reset to 0.
- R2: A 16-bit value completes only as the sequence high byte then low byte. A low byte written without an armed high byte is discarded. A second high byte written before the low byte replaces the first one.
- R3: With `clk_sel` non-zero, a completed pair is copied into its active register only on the clock edge where the counter steps up from limit−1 to the limit. The new value therefore already applies at count = limit.
- R4: In edge-aligned mode (`center_mode`=0) the counter runs 0..limit and wraps to 0. `pwm_out` is 1 while count < threshold. `ovf_flag` is 1 for exactly one cycle, in the cycle after the wrap, while the count is 0.
- R5: In center-aligned mode the counter runs 0 up to limit, then down to 1, then 0. Each period is 2·limit cycles. `pwm_out` is 1 while count < threshold. `ovf_flag` pulses once per period, in the cycle where the count first returns to 0.
- R6: In center-aligned mode a threshold ≥ limit holds `pwm_out` at 1 for the whole period.
- R7: In center-aligned mode a threshold of limit−1 drives `pwm_out` low only at counts limit−1 and limit, which is 3 of 2·limit cycles.
- R8: In center-aligned mode, changing the threshold from 0 to non-zero has no effect on the output at the count-0 point of the current period. The new pulse appears from the next limit crossing onward.
- R9: Changing the threshold from non-zero to 0 leaves the pulse of the current period intact. A threshold of 0 holds `pwm_out` low.
- R10: A modulo value of 0 makes the limit 0xFFFF (free-running). Loads then occur on the step from 0xFFFE to 0xFFFF.
- R11: Writing the control strobe `wr_ctrl` while `dbg_halt` is 0 discards a half-written or completed modulo pair. While `dbg_halt` is 1 the strobe leaves the modulo pair untouched.
- R12: While `clk_sel` is 00 the counter holds its value. A completed pair loads on the next clock edge.
- R13: While `dbg_halt` is 1 the counter holds its value and no period-boundary load happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_sel | input | 2 | Counter clock enable field; 00 stops the counter |
| center_mode | input | 1 | 1 = center-aligned (up/down), 0 = edge-aligned (up) |
| dbg_halt | input | 1 | Debug halt: freezes the counter, shields the modulo pair from `wr_ctrl` |
| wr_mod_hi | input | 1 | Write strobe, modulo high byte |
| wr_mod_lo | input | 1 | Write strobe, modulo low byte |
| wr_val_hi | input | 1 | Write strobe, threshold high byte |
| wr_val_lo | input | 1 | Write strobe, threshold low byte |
| wr_ctrl | input | 1 | Write strobe, control register |
| wr_data | input | 8 | Byte written by any strobe |
| pwm_out | output | 1 | PWM output |
| ovf_flag | output | 1 | One-cycle pulse at the end of each period |

## Verification
The bench builds the block with its default byte width of 8, so the counter is 16 bits wide. At that width the free-running limit of 0xFFFF produces a period of 65,536 cycles. This is short enough for the bench to cross the 0xFFFE→0xFFFF load point twice. All other cases use small limits (4, 8 and 9) that are written at run time. With these limits a bench can cover many edge and center periods in a few hundred cycles. That makes the limit−1 load point, the 100 % and near-100 % thresholds and the mid-period threshold changes cheap to reach.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        CT_IDLE = 2'd0,
        CT_UP   = 2'd1,
        CT_DOWN = 2'd2
    } cnt_state_e;

    typedef enum logic [1:0] {
        PB_EMPTY = 2'd0,
        PB_HALF  = 2'd1,
        PB_FULL  = 2'd2
    } pair_state_e;

endpackage

// File: rtl/pwm_pair_buf.sv
module pwm_pair_buf
    import pwm_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic              clr,
    input  logic              load_ok,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              take,
    output logic [VAL_W-1:0]  pair_val
);

    pair_state_e      st_q, st_d;
    logic [BYTE_W-1:0] hi_q, lo_q;

    // A completed pair is handed over whenever the owner allows a load.
    always_comb take = (st_q == PB_FULL) && load_ok;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PB_EMPTY: begin
                if (wr_hi) st_d = PB_HALF;
            end
            PB_HALF: begin
                if (wr_hi)      st_d = PB_HALF;
                else if (wr_lo) st_d = PB_FULL;
                else if (clr)   st_d = PB_EMPTY;
            end
            PB_FULL: begin
                if (wr_hi)      st_d = PB_HALF;
                else if (clr)   st_d = PB_EMPTY;
                else if (take)  st_d = PB_EMPTY;
            end
            default: st_d = PB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PB_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (wr_hi)                       hi_q <= wr_data;
            if (wr_lo && st_q == PB_HALF && !wr_hi) lo_q <= wr_data;
        end
    end

    assign pair_val = {hi_q, lo_q};

endmodule

// File: rtl/pwm_cnt_fsm.sv
module pwm_cnt_fsm
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             center,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt,
    output logic             load_step,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] up_cnt;
    cnt_state_e       up_st;
    logic             rising;

    // Edge mode always rises; center mode rises outside the falling phase.
    always_comb rising = (st_q != CT_DOWN) || !center;

    always_comb load_step = run && rising && (cnt == top - ONE);

    always_comb begin
        if (cnt >= top) begin
            if (center) begin
                up_cnt = cnt - ONE;
                up_st  = CT_DOWN;
            end else begin
                up_cnt = '0;
                up_st  = CT_UP;
            end
        end else begin
            up_cnt = cnt + ONE;
            up_st  = CT_UP;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt;
        if (run) begin
            unique case (st_q)
                CT_IDLE, CT_UP: begin
                    st_d  = up_st;
                    cnt_d = up_cnt;
                end
                CT_DOWN: begin
                    if (!center) begin
                        st_d  = up_st;
                        cnt_d = up_cnt;
                    end else if (cnt == '0) begin
                        st_d  = CT_UP;
                        cnt_d = ONE;
                    end else begin
                        st_d  = CT_DOWN;
                        cnt_d = cnt - ONE;
                    end
                end
                default: begin
                    st_d  = CT_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CT_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            cnt <= cnt_d;
            ovf <= run && (cnt_d == '0) && (cnt != '0);
        end
    end

endmodule

// File: rtl/pwm_buf_timer.sv
module pwm_buf_timer
    import pwm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        clk_sel,
    input  logic              center_mode,
    input  logic              dbg_halt,
    input  logic              wr_mod_hi,
    input  logic              wr_mod_lo,
    input  logic              wr_val_hi,
    input  logic              wr_val_lo,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              pwm_out,
    output logic              ovf_flag
);

    localparam int CNT_W   = 2 * BYTE_W;
    localparam int N_PAIRS = 2;
    localparam int IDX_MOD = 0;
    localparam int IDX_VAL = 1;

    logic             clk_on;
    logic             run;
    logic             load_step;
    logic             load_ok;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mod_act;
    logic [CNT_W-1:0] val_act;
    logic [CNT_W-1:0] top_val;

    logic [N_PAIRS-1:0] p_hi, p_lo, p_clr, p_take;
    logic [CNT_W-1:0]   p_val [N_PAIRS];

    always_comb begin
        clk_on  = |clk_sel;
        run     = clk_on && !dbg_halt;
        top_val = (mod_act == '0) ? '1 : mod_act;
        load_ok = !clk_on || load_step;
    end

    assign p_hi  = {wr_val_hi, wr_mod_hi};
    assign p_lo  = {wr_val_lo, wr_mod_lo};
    assign p_clr = {1'b0, wr_ctrl && !dbg_halt};

    for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
        pwm_pair_buf #(.BYTE_W(BYTE_W)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hi   (p_hi[i]),
            .wr_lo   (p_lo[i]),
            .clr     (p_clr[i]),
            .load_ok (load_ok),
            .wr_data (wr_data),
            .take    (p_take[i]),
            .pair_val(p_val[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_act <= '0;
            val_act <= '0;
        end else begin
            if (p_take[IDX_MOD]) mod_act <= p_val[IDX_MOD];
            if (p_take[IDX_VAL]) val_act <= p_val[IDX_VAL];
        end
    end

    pwm_cnt_fsm #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .center   (center_mode),
        .top      (top_val),
        .cnt      (cnt_q),
        .load_step(load_step),
        .ovf      (ovf_flag)
    );

    // Output decode: center mode forces a full pulse once the threshold reaches the limit.
    always_comb begin
        if (center_mode) pwm_out = (val_act >= top_val) || (cnt_q < val_act);
        else             pwm_out = (cnt_q < val_act);
    end

endmodule

// File: rtl/pwm_buf_timer_chk.sv
module pwm_buf_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       clk_sel,
    input logic             dbg_halt,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] top,
    input logic [CNT_W-1:0] val_act,
    input logic [CNT_W-1:0] mod_act,
    input logic             ovf_flag
);

    // R12 / R13: a stopped or halted counter keeps its value
    p_halt_freeze_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'b00 || dbg_halt) |=> $stable(cnt));

    // R3: threshold changes only on the limit-1 -> limit step while clocked
    p_val_load_point_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_sel) != 2'b00 && val_act != $past(val_act))
        |-> ($past(cnt) + 1'b1 == $past(top)));

    // R10: modulo changes only on the same boundary step
    p_mod_load_point_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_sel) != 2'b00 && mod_act != $past(mod_act))
        |-> ($past(cnt) + 1'b1 == $past(top)));

    // R4: overflow marks count zero
    p_ovf_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (cnt == '0));

    // R5: overflow is a single-cycle pulse
    p_ovf_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> !ovf_flag);

endmodule

bind pwm_buf_timer pwm_buf_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_sel (clk_sel),
    .dbg_halt(dbg_halt),
    .cnt     (cnt_q),
    .top     (top_val),
    .val_act (val_act),
    .mod_act (mod_act),
    .ovf_flag(ovf_flag)
);

// File: tb/pwm_buf_timer_tb.sv
`timescale 1ns/1ps
module pwm_buf_timer_tb;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MAXC   = (1 << CNT_W) - 1;
    localparam int BMASK  = (1 << BYTE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        clk_sel = 2'b00;
    logic              center_mode = 1'b0;
    logic              dbg_halt = 1'b0;
    logic              wr_mod_hi = 1'b0, wr_mod_lo = 1'b0;
    logic              wr_val_hi = 1'b0, wr_val_lo = 1'b0;
    logic              wr_ctrl = 1'b0;
    logic [BYTE_W-1:0] wr_data = '0;
    logic              pwm_out, ovf_flag;

    pwm_buf_timer #(.BYTE_W(BYTE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .center_mode(center_mode),
        .dbg_halt(dbg_halt), .wr_mod_hi(wr_mod_hi), .wr_mod_lo(wr_mod_lo),
        .wr_val_hi(wr_val_hi), .wr_val_lo(wr_val_lo), .wr_ctrl(wr_ctrl),
        .wr_data(wr_data), .pwm_out(pwm_out), .ovf_flag(ovf_flag)
    );

    always #2.5 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_st, m_mod, m_val, m_ovf;   // m_st: 0 idle, 1 rising, 2 falling
    int m_ps[2], m_hi[2], m_lo[2];          // ps: 0 empty, 1 half, 2 full

    always @(posedge clk) begin : model
        int  top, nc, ns, nmod, nval;
        bit  run, up, ldok;
        bit  ld[2], whi[2], wlo[2];
        if (!rst_n) begin
            m_cnt = 0; m_st = 0; m_mod = 0; m_val = 0; m_ovf = 0;
            for (int i = 0; i < 2; i++) begin m_ps[i] = 0; m_hi[i] = 0; m_lo[i] = 0; end
        end else begin
            run  = (clk_sel != 2'b00) && !dbg_halt;
            top  = (m_mod == 0) ? MAXC : m_mod;
            up   = (m_st != 2) || !center_mode;
            ldok = (clk_sel == 2'b00) || (run && up && m_cnt == top - 1);
            whi[0] = wr_mod_hi; wlo[0] = wr_mod_lo;
            whi[1] = wr_val_hi; wlo[1] = wr_val_lo;
            nmod = m_mod; nval = m_val;
            for (int i = 0; i < 2; i++) ld[i] = (m_ps[i] == 2) && ldok;
            if (ld[0]) nmod = (m_hi[0] << BYTE_W) | m_lo[0];
            if (ld[1]) nval = (m_hi[1] << BYTE_W) | m_lo[1];
            for (int i = 0; i < 2; i++) begin
                if (whi[i]) begin m_hi[i] = int'(wr_data); m_ps[i] = 1; end
                else if (wlo[i] && m_ps[i] == 1) begin m_lo[i] = int'(wr_data); m_ps[i] = 2; end
                else if (i == 0 && wr_ctrl && !dbg_halt) m_ps[i] = 0;
                else if (ld[i]) m_ps[i] = 0;
            end
            nc = m_cnt; ns = m_st;
            if (run) begin
                if (up) begin
                    if (m_cnt >= top) begin
                        if (center_mode) begin nc = m_cnt - 1; ns = 2; end
                        else begin nc = 0; ns = 1; end
                    end else begin nc = m_cnt + 1; ns = 1; end
                end else if (m_cnt == 0) begin nc = 1; ns = 1; end
                else nc = m_cnt - 1;
            end
            m_ovf = (run && nc == 0 && m_cnt != 0) ? 1 : 0;
            m_cnt = nc; m_st = ns; m_mod = nmod; m_val = nval;
        end
    end

    function automatic int exp_pwm();
        int top;
        top = (m_mod == 0) ? MAXC : m_mod;
        if (center_mode) return ((m_val >= top) || (m_cnt < m_val)) ? 1 : 0;
        return (m_cnt < m_val) ? 1 : 0;
    endfunction

    // Per-cycle comparison, sampled 1 ns after the falling edge.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(pwm_out === exp_pwm()[0], "R4/R5 pwm_out vs model", int'(pwm_out), exp_pwm());
            check(ovf_flag === m_ovf[0], "R4/R5 ovf_flag vs model", int'(ovf_flag), m_ovf);
        end
    end

    // ---------------- stimulus helpers ----------------
    // which: 0 mod hi, 1 mod lo, 2 val hi, 3 val lo, 4 ctrl
    task automatic wr(input int which, input int data);
        wr_data   = BYTE_W'(data);
        wr_mod_hi = (which == 0);
        wr_mod_lo = (which == 1);
        wr_val_hi = (which == 2);
        wr_val_lo = (which == 3);
        wr_ctrl   = (which == 4);
        @(negedge clk);
        {wr_mod_hi, wr_mod_lo, wr_val_hi, wr_val_lo, wr_ctrl} = '0;
    endtask

    task automatic wr16(input int hi_sel, input int v);
        wr(hi_sel, (v >> BYTE_W) & BMASK);
        wr(hi_sel + 1, v & BMASK);
    endtask

    task automatic wait_ovf();
        int k = 0;
        @(negedge clk);
        while (!ovf_flag && k < 70000) begin @(negedge clk); k++; end
        if (k >= 70000) check(1'b0, "R4 overflow never seen", 0, 1);
    endtask

    task automatic count_win(input int n, output int hi, output int ov);
        hi = 0; ov = 0;
        for (int j = 0; j < n; j++) begin
            if (j > 0) @(negedge clk);
            hi += int'(pwm_out);
            ov += int'(ovf_flag);
        end
    endtask

    task automatic period(output int p);
        wait_ovf();
        p = 0;
        do begin @(negedge clk); p++; end while (!ovf_flag && p < 70000);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            finish_up();
        end
    end

    initial begin
        int h, o, p;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(pwm_out == 1'b0, "R1 pwm after reset", int'(pwm_out), 0);
        check(ovf_flag == 1'b0, "R1 ovf after reset", int'(ovf_flag), 0);

        // R12: clock off, pairs load at once (limit 9, threshold 4)
        wr16(0, 9);
        wr16(2, 4);
        repeat (2) @(negedge clk);
        check(pwm_out == 1'b1, "R12 immediate load while stopped", int'(pwm_out), 1);

        // R4: edge mode, 10-cycle period, 4 high
        clk_sel = 2'b01;
        wait_ovf();
        count_win(30, h, o);
        check(o == 3, "R4 overflow pulses in 3 periods", o, 3);
        wait_ovf();
        count_win(10, h, o);
        check(h == 4, "R4 edge duty count", h, 4);

        // R2: high byte alone has no effect
        wr(2, 0);
        repeat (2) wait_ovf();
        count_win(10, h, o);
        check(h == 4, "R2 lone high byte ignored", h, 4);
        // R2: second high byte replaces first
        wr(2, 1); wr(2, 0); wr(3, 7);
        repeat (2) wait_ovf();
        count_win(10, h, o);
        check(h == 7, "R2 restarted pair", h, 7);

        // R3: new value applies already at count = limit
        wait_ovf();
        fork
            count_win(10, h, o);
            wr16(2, 10);
        join
        check(h == 8, "R3 load at limit-1 to limit", h, 8);
        wait_ovf();
        count_win(10, h, o);
        check(h == 10, "R3 following period full", h, 10);

        // R9: non-zero to zero finishes current pulse
        wr16(2, 5);
        repeat (2) wait_ovf();
        fork
            count_win(10, h, o);
            wr16(2, 0);
        join
        check(h == 5, "R9 old pulse kept", h, 5);
        wait_ovf();
        count_win(10, h, o);
        check(h == 0, "R9 zero threshold low", h, 0);

        // R11: control write outside halt discards modulo pair
        wr(0, 0); wr(4, 0); wr(1, 4);
        period(p);
        check(p == 10, "R11 pair dropped by ctrl write", p, 10);
        // R11: control write during halt keeps the pair
        wr(0, 0);
        dbg_halt = 1'b1;
        wr(4, 0);
        dbg_halt = 1'b0;
        wr(1, 4);
        period(p);
        period(p);
        check(p == 5, "R11 pair kept under halt", p, 5);

        // R13: halt freezes the counter for 6 cycles
        wait_ovf();
        fork
            begin
                p = 0;
                do begin @(negedge clk); p++; end while (!ovf_flag && p < 70000);
            end
            begin
                @(negedge clk);
                dbg_halt = 1'b1;
                repeat (6) @(negedge clk);
                dbg_halt = 1'b0;
            end
        join
        check(p == 11, "R13 halted period", p, 11);

        // R5: center mode, limit 8, threshold 3
        center_mode = 1'b1;
        wr16(0, 8);
        wr16(2, 3);
        repeat (3) wait_ovf();
        count_win(16, h, o);
        check(h == 5, "R5 center duty count", h, 5);
        check(o == 1, "R5 one overflow per period", o, 1);

        // R6: threshold = limit
        wr16(2, 8);
        repeat (2) wait_ovf();
        count_win(16, h, o);
        check(h == 16, "R6 full duty", h, 16);

        // R7: threshold = limit-1
        wr16(2, 7);
        repeat (2) wait_ovf();
        count_win(16, h, o);
        check(h == 13, "R7 near-full duty", h, 13);

        // R8: zero to non-zero waits for the limit crossing
        wr16(2, 0);
        repeat (2) wait_ovf();
        count_win(16, h, o);
        check(h == 0, "R9 center zero threshold", h, 0);
        wait_ovf();
        fork
            count_win(8, h, o);
            wr16(2, 3);
        join
        check(h == 0, "R8 no mid-period pulse", h, 0);
        wait_ovf();
        count_win(16, h, o);
        check(h == 5, "R8 pulse from next period", h, 5);

        // R10: free-running limit 0xFFFF
        clk_sel = 2'b00;
        center_mode = 1'b0;
        wr16(0, 0);
        wr16(2, 2);
        repeat (2) @(negedge clk);
        clk_sel = 2'b01;
        wait_ovf();
        fork
            begin
                repeat (100) @(negedge clk);
                check(pwm_out == 1'b0, "R10 no load before 0xFFFF", int'(pwm_out), 0);
            end
            wr16(2, 5);
        join
        wait_ovf();
        count_win(10, h, o);
        check(h == 5, "R10 load at free-run boundary", h, 5);

        finish_up();
    end

endmodule